// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates interrupt requests for a small processor core. It collects requests from a parameterised group of ordinary sources, each given one of three programmable levels. It also collects a fixed group of top-level fault requests that can never be masked, a fixed group of top-level debug requests that software can gate, and one software request that ranks below every ordinary level. Each cycle it picks the winning request and checks it against the level of the handler the core is running. It then presents the winning source number, its level and a vector address.

The vector address is a programmable table base plus the source number scaled by a fixed entry size. Two fast-interrupt slots can each be bound to any ordinary source. A bound source ranks ahead of unbound sources at the same level and uses a vector from the slot's own register instead of the table. While the core sleeps, any enabled pending request raises a wake request to the clock logic, whatever the current mask. Edge-type sources stay pending until the core acknowledges them.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_valid` and `wake_req` are 0. Every ordinary source is disabled, the table base is 0, both fast slots are unbound and all debug enables are clear.
- R2: An ordinary source's config register (address 8+i) uses bits [1:0] for level, bit 2 for enable and bit 3 for edge mode. Level codes on `irq_lvl` are: software 1, level0 2, level1 3, level2 4, top 5. Field values 0, 1 and 2 map to codes 2, 3 and 4, and field value 3 is treated as level2 (code 4).
- R3: A request other than a fault request is presented only when its level code is strictly greater than `core_level`. Otherwise it stays pending and is presented once `core_level` drops below it.
- R4: Fault requests (`fault_req`, source numbers 0..3, code 5) need no enable and are presented whatever the value of `core_level`, including 5.
- R5: Debug requests (`dbg_req`, source numbers 4..6, code 5) are presented only when their enable bit in register 1, bits [2:0], is set, and only when `core_level` is below 5.
- R6: The highest level code wins. At equal codes a source bound to a fast slot beats an unbound one. After that, the lowest source number wins. Ordinary source i has number 8+i.
- R7: For a request not bound to a fast slot, `irq_vec` equals the table base (register 0) plus the source number shifted left by ENT_SH (default 1).
- R8: Fast slot registers 2 and 3 hold a bind bit in bit AW-1 and a source index in the low bits. Registers 4 and 5 hold the slot vectors. A bound winner raises `irq_fast`, and `irq_vec` shows its slot's vector, with slot 0 taking precedence.
- R9: An edge-mode source latches a rising input edge and stays pending after its input falls. The pending bit is cleared by `irq_ack` while that source is presented. For a level-mode source, pending follows the input and `irq_ack` has no effect.
- R10: `wake_req` is high exactly when `lp_mode` is high and any enabled request is pending, independent of `core_level`.
- R11: The software request (`swlp_req`, source number 7, code 1) needs no enable and is presented only when `core_level` is 0.
- R12: A request from a disabled ordinary source is neither presented nor counted for wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | IW | Register address |
| cfg_wdata | input | AW | Register write data |
| src_req | input | NSRC | Ordinary source requests |
| fault_req | input | 4 | Unmaskable top-level requests |
| dbg_req | input | 3 | Gateable top-level debug requests |
| swlp_req | input | 1 | Lowest-level software request |
| core_level | input | 3 | Level code of the running handler (0 = none) |
| lp_mode | input | 1 | System is in wait or stop |
| irq_ack | input | 1 | Core accepts the presented request |
| irq_valid | output | 1 | A request is presented |
| irq_idx | output | IW | Winning source number |
| irq_lvl | output | 3 | Winning level code |
| irq_vec | output | AW | Vector address |
| irq_fast | output | 1 | Winner is bound to a fast slot |
| wake_req | output | 1 | Wake request to clock control |

## Verification
The presentation outputs are computed combinationally from registered configuration and pending state. A corrupted level field, enable bit or fast binding therefore shows up on `irq_idx`, `irq_lvl` or `irq_vec` in the very next cycle that a request is raised. A pending bit stuck high after acknowledge shows up as a repeated presentation of the same source one cycle after `irq_ack`. A pending bit stuck low shows up as a missing request one cycle after the input edge. A wrong mask comparison shows up as a request that appears or vanishes as `core_level` steps past its level code.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC   = 8,
  parameter int AW     = 16,
  parameter int ENT_SH = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [$clog2(NSRC+8)-1:0]     cfg_addr,
  input  logic [AW-1:0]                 cfg_wdata,
  input  logic [NSRC-1:0]               src_req,
  input  logic [3:0]                    fault_req,
  input  logic [2:0]                    dbg_req,
  input  logic                          swlp_req,
  input  logic [2:0]                    core_level,
  input  logic                          lp_mode,
  input  logic                          irq_ack,
  output logic                          irq_valid,
  output logic [$clog2(NSRC+8)-1:0]     irq_idx,
  output logic [2:0]                    irq_lvl,
  output logic [AW-1:0]                 irq_vec,
  output logic                          irq_fast,
  output logic                          wake_req
);
  localparam int NT = NSRC + 8;
  localparam int IW = $clog2(NT);
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [AW-1:0]   vbase;
  logic [2:0]      dbg_en;
  logic [1:0]      fs_v;
  logic [SW-1:0]   fs_idx [2];
  logic [AW-1:0]   fvec [2];
  logic [1:0]      s_prio [NSRC];
  logic [NSRC-1:0] s_en, s_edge, prev, epend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vbase  <= '0;
      dbg_en <= '0;
      fs_v   <= '0;
      s_en   <= '0;
      s_edge <= '0;
      for (int j = 0; j < 2; j++) begin
        fs_idx[j] <= '0;
        fvec[j]   <= '0;
      end
      for (int i = 0; i < NSRC; i++) s_prio[i] <= '0;
    end else if (cfg_we) begin
      case (int'(cfg_addr))
        0: vbase  <= cfg_wdata;
        1: dbg_en <= cfg_wdata[2:0];
        2: begin fs_v[0] <= cfg_wdata[AW-1]; fs_idx[0] <= cfg_wdata[SW-1:0]; end
        3: begin fs_v[1] <= cfg_wdata[AW-1]; fs_idx[1] <= cfg_wdata[SW-1:0]; end
        4: fvec[0] <= cfg_wdata;
        5: fvec[1] <= cfg_wdata;
        default: ;
      endcase
      for (int i = 0; i < NSRC; i++)
        if (int'(cfg_addr) == 8 + i) begin
          s_prio[i] <= cfg_wdata[1:0];
          s_en[i]   <= cfg_wdata[2];
          s_edge[i] <= cfg_wdata[3];
        end
    end
  end

  logic          ack_hit;
  logic [IW-1:0] ack_off;
  logic [SW-1:0] ack_sel;
  logic [NSRC-1:0] rise, clr;

  assign ack_hit = irq_ack && irq_valid && (irq_idx >= IW'(8));
  assign ack_off = irq_idx - IW'(8);
  assign ack_sel = ack_off[SW-1:0];
  assign rise    = src_req & ~prev;
  assign clr     = ack_hit ? (NSRC'(1) << ack_sel) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev  <= '0;
      epend <= '0;
    end else begin
      prev  <= src_req;
      epend <= (epend & ~clr) | rise;
    end
  end

  logic [NT-1:0] c_ok, c_nmi, c_fast, c_slot;
  logic [2:0]    c_rank [NT];

  for (genvar g = 0; g < 4; g++) begin : g_fault
    assign c_ok[g] = fault_req[g];
    assign c_nmi[g] = 1'b1;
    assign c_fast[g] = 1'b0;
    assign c_slot[g] = 1'b0;
    assign c_rank[g] = 3'd5;
  end

  for (genvar g = 0; g < 3; g++) begin : g_dbg
    assign c_ok[4+g] = dbg_req[g] & dbg_en[g];
    assign c_nmi[4+g] = 1'b0;
    assign c_fast[4+g] = 1'b0;
    assign c_slot[4+g] = 1'b0;
    assign c_rank[4+g] = 3'd5;
  end

  assign c_ok[7]   = swlp_req;
  assign c_nmi[7]  = 1'b0;
  assign c_fast[7] = 1'b0;
  assign c_slot[7] = 1'b0;
  assign c_rank[7] = 3'd1;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic h0, h1;
    assign h0 = fs_v[0] && (fs_idx[0] == SW'(g));
    assign h1 = fs_v[1] && (fs_idx[1] == SW'(g));
    assign c_ok[8+g]   = s_en[g] & (s_edge[g] ? epend[g] : src_req[g]);
    assign c_nmi[8+g]  = 1'b0;
    assign c_fast[8+g] = h0 | h1;
    assign c_slot[8+g] = ~h0;
    assign c_rank[8+g] = (s_prio[g] == 2'd3) ? 3'd4 : 3'd2 + {1'b0, s_prio[g]};
  end

  logic          sel_ok, sel_fast, sel_slot;
  logic [2:0]    sel_rank;
  logic [IW-1:0] sel_idx;

  always_comb begin
    sel_ok   = 1'b0;
    sel_fast = 1'b0;
    sel_slot = 1'b0;
    sel_rank = '0;
    sel_idx  = '0;
    for (int k = 0; k < NT; k++)
      if (c_ok[k] && (c_nmi[k] || c_rank[k] > core_level))
        if (!sel_ok || {c_rank[k], c_fast[k]} > {sel_rank, sel_fast}) begin
          sel_ok   = 1'b1;
          sel_rank = c_rank[k];
          sel_fast = c_fast[k];
          sel_slot = c_slot[k];
          sel_idx  = IW'(k);
        end
  end

  assign irq_valid = sel_ok;
  assign irq_idx   = sel_idx;
  assign irq_lvl   = sel_ok ? sel_rank : 3'd0;
  assign irq_fast  = sel_ok & sel_fast;
  assign irq_vec   = !sel_ok ? '0 :
                     sel_fast ? fvec[sel_slot] :
                     vbase + (AW'(sel_idx) << ENT_SH);
  assign wake_req  = lp_mode & (|c_ok);

  assert_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_idx >= IW'(4)) |-> (irq_lvl > core_level));

  assert_fault_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_req) |-> (irq_valid && irq_lvl == 3'd5 && irq_idx < IW'(4)));

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && s_edge[ack_sel] && !src_req[ack_sel]) |=> !epend[$past(ack_sel)]);

  assert_wake_sleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> lp_mode);

  assert_fast_ordinary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fast |-> (irq_valid && irq_idx >= IW'(8)));

  assert_sw_lowest_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_idx == IW'(7)) |-> (core_level == 3'd0));
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [3:0] cfg_addr = 0;
  logic [15:0] cfg_wdata = 0;
  logic [7:0] src_req = 0;
  logic [3:0] fault_req = 0;
  logic [2:0] dbg_req = 0;
  logic swlp_req = 0, lp_mode = 0, irq_ack = 0;
  logic [2:0] core_level = 0;
  logic irq_valid, irq_fast, wake_req;
  logic [3:0] irq_idx;
  logic [2:0] irq_lvl;
  logic [15:0] irq_vec;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .src_req(src_req), .fault_req(fault_req), .dbg_req(dbg_req), .swlp_req(swlp_req),
    .core_level(core_level), .lp_mode(lp_mode), .irq_ack(irq_ack),
    .irq_valid(irq_valid), .irq_idx(irq_idx), .irq_lvl(irq_lvl), .irq_vec(irq_vec),
    .irq_fast(irq_fast), .wake_req(wake_req));

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic chk(input string tag, input bit ev, input int eidx, input int elvl,
                     input int evec, input bit efast);
    checks++;
    if (irq_valid !== ev || (ev && (int'(irq_idx) != eidx || int'(irq_lvl) != elvl ||
        int'(irq_vec) != evec || irq_fast !== efast))) begin
      errors++;
      $display("FAIL %s: actual v=%0b idx=%0d lvl=%0d vec=%h fast=%0b expected v=%0b idx=%0d lvl=%0d vec=%h fast=%0b",
               tag, irq_valid, irq_idx, irq_lvl, irq_vec, irq_fast, ev, eidx, elvl, evec[15:0], efast);
    end
  endtask

  task automatic chkw(input string tag, input bit ew);
    checks++;
    if (wake_req !== ew) begin
      errors++;
      $display("FAIL %s: actual wake=%0b expected wake=%0b", tag, wake_req, ew);
    end
  endtask

  task automatic t_reset();
    src_req = 8'hFF;
    step();
    chk("R1 reset idle", 0, 0, 0, 0, 0);
    chkw("R1 reset no wake", 0);
    lp_mode = 1; step();
    chkw("R12 disabled source no wake", 0);
    chk("R12 disabled source not presented", 0, 0, 0, 0, 0);
    lp_mode = 0; src_req = 0;
  endtask

  task automatic t_basic();
    wr(0, 16'h1000);
    wr(8 + 3, 4'b0101);
    src_req[3] = 1; step();
    chk("R2 R7 level1 source", 1, 11, 3, 16'h1016, 0);
    core_level = 3; step();
    chk("R3 masked at equal level", 0, 0, 0, 0, 0);
    core_level = 2; step();
    chk("R3 released below level", 1, 11, 3, 16'h1016, 0);
    core_level = 0;
  endtask

  task automatic t_prio();
    wr(8 + 5, 4'b0111);
    src_req[5] = 1; step();
    chk("R2 field 3 clamps to level2", 1, 13, 4, 16'h101A, 0);
    wr(8 + 1, 4'b0110);
    src_req[1] = 1; step();
    chk("R6 tie lowest index", 1, 9, 4, 16'h1012, 0);
    wr(4, 16'h2000);
    wr(2, 16'h8005); step();
    chk("R8 R6 fast beats lower index", 1, 13, 4, 16'h2000, 1);
    wr(5, 16'h3000);
    wr(3, 16'h8005); step();
    chk("R8 slot0 vector precedence", 1, 13, 4, 16'h2000, 1);
    wr(2, 0); wr(3, 0);
    src_req = 0;
    wr(8 + 1, 0); wr(8 + 5, 0);
  endtask

  task automatic t_edge();
    wr(8 + 6, 4'b1100);
    @(negedge clk); src_req[6] = 1;
    @(negedge clk); src_req[6] = 0;
    step();
    chk("R9 edge latched after fall", 1, 14, 2, 16'h101C, 0);
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0; #1;
    chk("R9 ack clears edge pending", 0, 0, 0, 0, 0);
    src_req[3] = 1; step();
    chk("R9 level source present", 1, 11, 3, 16'h1016, 0);
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0; #1;
    chk("R9 ack no effect on level source", 1, 11, 3, 16'h1016, 0);
    src_req[3] = 0;
  endtask

  task automatic t_top();
    core_level = 5; fault_req = 4'b0100; step();
    chk("R4 fault at full mask", 1, 2, 5, 16'h1004, 0);
    fault_req = 0; core_level = 0;
    dbg_req = 3'b010; step();
    chk("R5 debug gated off", 0, 0, 0, 0, 0);
    wr(1, 16'h0002); step();
    chk("R5 debug enabled", 1, 5, 5, 16'h100A, 0);
    core_level = 5; step();
    chk("R5 debug masked at level5", 0, 0, 0, 0, 0);
    dbg_req = 0; core_level = 0;
  endtask

  task automatic t_sw();
    swlp_req = 1; step();
    chk("R11 software request", 1, 7, 1, 16'h100E, 0);
    core_level = 1; step();
    chk("R11 software masked", 0, 0, 0, 0, 0);
    core_level = 0; src_req[3] = 1; step();
    chk("R6 ordinary beats software", 1, 11, 3, 16'h1016, 0);
    swlp_req = 0; src_req[3] = 0;
  endtask

  task automatic t_wake();
    lp_mode = 1; core_level = 5; src_req[3] = 1; step();
    chkw("R10 wake despite mask", 1);
    chk("R10 masked while waking", 0, 0, 0, 0, 0);
    src_req[3] = 0; step();
    chkw("R10 no request no wake", 0);
    lp_mode = 0; src_req[3] = 1; step();
    chkw("R10 awake no wake", 0);
    src_req[3] = 0; core_level = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_prio();
    t_edge();
    t_top();
    t_sw();
    t_wake();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule